// File: doc/BRIEF.md
# Fuse-Map Programming Controller with Security Lock

This block is the command front end for the configuration store of a small programmable logic array. That store holds the AND-array connection bits and the macrocell configuration bits. A host issues one of four commands on a valid/busy interface: bulk erase, program one word, verify (read) one word, and set the security lock. The controller then drives the write strobe, address and write data of an external fuse word store, and returns read data for a verify.

The security lock guards the design against readout and modification. While the lock is set, program and verify requests are refused, and a refused verify returns all-zero data. The only way to clear the lock is a full bulk erase. That erase opens every connection by writing zero to every word of the store, and the lock drops as the last word is written. The lock can be set by its own command, or by a flag on a program command, in which case it takes effect when that write completes. Erase and program each last a fixed number of cycles. The storage cell timing is outside this block.

Top module: `fusectl_top`

## Requirements
- R1: While reset is held, and at its release, `busy`, `done`, `cmd_err`, `secured`, `fuse_we` and `rd_data` are all zero.
- R2: `cmd_op` encodes erase = 2'b00, program = 2'b01, verify = 2'b10 and secure = 2'b11. A command is taken only on a clock edge where `cmd_valid` is high and `busy` is low. A command presented while `busy` is high is dropped with no error, no done pulse and no write.
- R3: Bulk erase holds `busy` for exactly NUM_WORDS cycles (16 by default). It asserts `fuse_we` in every one of those cycles, with `fuse_wdata` = 0 and `fuse_addr` stepping from 0 up to NUM_WORDS-1, one address per cycle. `done` pulses for one cycle as `busy` falls.
- R4: Program with the lock clear holds `busy` for PROG_CYCLES cycles (4 by default). In each of those cycles it drives `fuse_we` with the captured address and data. `done` pulses for one cycle after the last write.
- R5: Verify with the lock clear holds `busy` for one cycle, drives the captured address to the store, then loads `rd_data` with the addressed word and pulses `done`.
- R6: Secure sets `secured` and pulses `done` on the cycle after acceptance, without raising `busy`. Secure is also accepted when the lock is already set.
- R7: A program command taken with `cmd_lock` high sets `secured` together with its `done` pulse.
- R8: A program command while `secured` is high is refused. `cmd_err` is high for the following cycle, and `busy`, `done` and `fuse_we` stay low.
- R9: A verify command while `secured` is high is refused. `cmd_err` is high for the following cycle, `rd_data` becomes all zero, and `done` stays low.
- R10: `secured` falls only at the end of a bulk erase. When it falls, every word of the store reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word address for program and verify |
| cmd_wdata | input | DATA_W | Word to program |
| cmd_lock | input | 1 | Set the lock when this program completes |
| busy | output | 1 | A multi-cycle command is running |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle refusal pulse |
| rd_data | output | DATA_W | Verify result |
| secured | output | 1 | Security lock state |
| fuse_we | output | 1 | Store write strobe |
| fuse_addr | output | ADDR_W | Store word address |
| fuse_wdata | output | DATA_W | Store write data |
| fuse_rdata | input | DATA_W | Store read data for the current address |

## Verification
The bench targets the lock boundaries, and each has a typical way to go wrong:
- A refused program could still pulse the write strobe and alter the store.
- A refused verify could leak the stored word on `rd_data` instead of zeros.
- A secure or program command could be allowed to clear the lock.
- A verify issued in the middle of a program could be accepted and corrupt the captured address.

The erase walk is compared every cycle for its length, its address order and its single done pulse. An off-by-one erase would skip the top word or hold `busy` for seventeen cycles. A design that cleared the lock at the start of erase rather than the end would expose a half-wiped design.

// File: rtl/fusectl_pkg.sv
// Package: shared command and state encodings for the fuse controller.
// Assumes: command codes are fixed by the host interface (see R2).
package fusectl_pkg;

    typedef enum logic [1:0] {
        OP_ERASE  = 2'b00,
        OP_PROG   = 2'b01,
        OP_VERIFY = 2'b10,
        OP_SECURE = 2'b11
    } fuse_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_PROG   = 2'd2,
        ST_VERIFY = 2'd3
    } fuse_state_e;

endpackage

// File: rtl/fusectl_lock.sv
// Module: security lock bit.
// What it does: holds the lock flag; a clear request overrides a set request.
// Assumes: clear is raised only at the end of a bulk erase by the sequencer.
module fusectl_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic locked_o
);

    // Purpose: update the lock flag, clear taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
        end else if (clr_i) begin
            locked_o <= 1'b0;
        end else if (set_i) begin
            locked_o <= 1'b1;
        end
    end

    AST_UNLOCK_ONLY_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(clr_i)); // R10

    AST_LOCK_ONLY_BY_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(set_i)); // R6

endmodule

// File: rtl/fusectl_walker.sv
// Module: cycle/address walker for fixed-length operations.
// What it does: counts from 0 up to a limit after a start pulse, flags the
// final count, then stops.
// Assumes: limit_i is stable while the walk runs; start_i is ignored only
// by convention of the caller (it restarts the walk).
module fusectl_walker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic running_q;

    // Purpose: advance the count while running, stop after the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_o     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            cnt_o     <= '0;
        end else if (running_q) begin
            if (cnt_o == limit_i) begin
                running_q <= 1'b0;
                cnt_o     <= '0;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    // Purpose: mark the final cycle of the walk.
    always_comb begin
        last_o = running_q && (cnt_o == limit_i);
    end

    AST_WALK_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cnt_o <= limit_i)); // R3

    AST_WALK_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && $past(running_q) && !$past(start_i)) |-> (cnt_o == $past(cnt_o) + 1'b1)); // R3

endmodule

// File: rtl/fusectl_ctrl.sv
// Module: command sequencer for the fuse store.
// What it does: accepts commands when idle, refuses program/verify while
// locked, runs erase/program through the walker, performs verify reads and
// drives the store write port.
// Assumes: the store returns fuse_rdata_i combinationally for fuse_addr_o.
module fusectl_ctrl
    import fusectl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 4,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  logic              cmd_lock_i,
    input  logic              locked_i,
    input  logic              walk_last_i,
    input  logic [CNT_W-1:0]  walk_cnt_i,
    input  logic [DATA_W-1:0] fuse_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              walk_start_o,
    output logic [CNT_W-1:0]  walk_limit_o,
    output logic              lock_set_o,
    output logic              lock_clr_o,
    output logic              fuse_we_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    output logic [DATA_W-1:0] fuse_wdata_o
);

    localparam int NUM_WORDS = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(NUM_WORDS - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);

    fuse_state_e       state_q;
    fuse_op_e          op_in;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              lock_after_q;

    // Purpose: decode the incoming command and the acceptance condition.
    always_comb begin
        op_in  = fuse_op_e'(cmd_op_i);
        accept = cmd_valid_i && (state_q == ST_IDLE);
    end

    // Purpose: start the walker for erase and for an allowed program.
    always_comb begin
        walk_start_o = accept && ((op_in == OP_ERASE) || ((op_in == OP_PROG) && !locked_i));
        walk_limit_o = (state_q == ST_ERASE) ? ERASE_LAST : PROG_LAST;
    end

    // Purpose: request lock set/clear from the lock register.
    always_comb begin
        lock_set_o = (accept && (op_in == OP_SECURE))
                  || ((state_q == ST_PROG) && walk_last_i && lock_after_q);
        lock_clr_o = (state_q == ST_ERASE) && walk_last_i;
    end

    // Purpose: main sequencer, completion and refusal pulses, verify data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            data_q       <= '0;
            lock_after_q <= 1'b0;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            rd_data_o    <= '0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (op_in)
                            OP_ERASE: begin
                                state_q <= ST_ERASE;
                            end
                            OP_PROG: begin
                                if (locked_i) begin
                                    err_o <= 1'b1;
                                end else begin
                                    state_q      <= ST_PROG;
                                    addr_q       <= cmd_addr_i;
                                    data_q       <= cmd_wdata_i;
                                    lock_after_q <= cmd_lock_i;
                                end
                            end
                            OP_VERIFY: begin
                                if (locked_i) begin
                                    err_o     <= 1'b1;
                                    rd_data_o <= '0;
                                end else begin
                                    state_q <= ST_VERIFY;
                                    addr_q  <= cmd_addr_i;
                                end
                            end
                            default: begin
                                done_o <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ERASE: begin
                    if (walk_last_i) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end
                end
                ST_PROG: begin
                    if (walk_last_i) begin
                        state_q      <= ST_IDLE;
                        done_o       <= 1'b1;
                        lock_after_q <= 1'b0;
                    end
                end
                default: begin
                    rd_data_o <= fuse_rdata_i;
                    done_o    <= 1'b1;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: drive the store write port and the busy flag.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        fuse_we_o    = (state_q == ST_ERASE) || (state_q == ST_PROG);
        fuse_addr_o  = (state_q == ST_ERASE) ? walk_cnt_i[ADDR_W-1:0] : addr_q;
        fuse_wdata_o = (state_q == ST_ERASE) ? '0 : data_q;
    end

    AST_NO_PROG_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> !locked_i); // R8

    AST_LOCKED_VERIFY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !busy_o && (cmd_op_i == 2'b10) && locked_i) |=> (err_o && (rd_data_o == '0) && !done_o)); // R9

    AST_LOCKED_PROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !busy_o && (cmd_op_i == 2'b01) && locked_i) |=> (err_o && !busy_o && !fuse_we_o)); // R8

    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && busy_o) |=> !err_o); // R2

    AST_ERASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ERASE) && ($past(state_q) == ST_ERASE)) |-> (fuse_addr_o == $past(fuse_addr_o) + 1'b1)); // R3

    AST_ERASE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> (fuse_we_o && (fuse_wdata_o == '0))); // R3

    AST_ERASE_ENDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_ERASE) && (state_q == ST_IDLE)) |-> (($past(fuse_addr_o) == ADDR_W'(NUM_WORDS - 1)) && done_o)); // R3

    AST_PROG_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PROG) && ($past(state_q) == ST_PROG)) |-> ($stable(fuse_addr_o) && $stable(fuse_wdata_o))); // R4

    AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R8

endmodule

// File: rtl/fusectl_top.sv
// Module: fuse-map programming controller top.
// What it does: ties the sequencer, the walker and the security lock
// together and exposes the command and store interfaces.
// Assumes: the external store has 2**ADDR_W words with combinational read.
module fusectl_top #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_lock,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              secured,
    output logic              fuse_we,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic [DATA_W-1:0] fuse_wdata,
    input  logic [DATA_W-1:0] fuse_rdata
);

    localparam int PC_W  = $clog2(PROG_CYCLES + 1);
    localparam int CNT_W = (ADDR_W > PC_W) ? ADDR_W : PC_W;

    logic             walk_start;
    logic [CNT_W-1:0] walk_limit;
    logic [CNT_W-1:0] walk_cnt;
    logic             walk_last;
    logic             lock_set;
    logic             lock_clr;

    fusectl_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES),
        .CNT_W       (CNT_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .cmd_addr_i   (cmd_addr),
        .cmd_wdata_i  (cmd_wdata),
        .cmd_lock_i   (cmd_lock),
        .locked_i     (secured),
        .walk_last_i  (walk_last),
        .walk_cnt_i   (walk_cnt),
        .fuse_rdata_i (fuse_rdata),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (cmd_err),
        .rd_data_o    (rd_data),
        .walk_start_o (walk_start),
        .walk_limit_o (walk_limit),
        .lock_set_o   (lock_set),
        .lock_clr_o   (lock_clr),
        .fuse_we_o    (fuse_we),
        .fuse_addr_o  (fuse_addr),
        .fuse_wdata_o (fuse_wdata)
    );

    fusectl_walker #(
        .CNT_W (CNT_W)
    ) i_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (walk_start),
        .limit_i (walk_limit),
        .cnt_o   (walk_cnt),
        .last_o  (walk_last)
    );

    fusectl_lock i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (lock_set),
        .clr_i    (lock_clr),
        .locked_o (secured)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !cmd_err && !secured && !fuse_we && (rd_data == '0))); // R1

    AST_SECURE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == 2'b11)) |=> (secured && done && !busy)); // R6

endmodule

// File: tb/test_fusectl_top.sv
module test_fusectl_top;

    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;
    localparam int PROG_CYCLES = 4;
    localparam int NUM_WORDS   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              cmd_lock = 1'b0;
    logic              busy, done, cmd_err, secured, fuse_we;
    logic [DATA_W-1:0] rd_data, fuse_wdata, fuse_rdata;
    logic [ADDR_W-1:0] fuse_addr;

    logic [DATA_W-1:0] store [NUM_WORDS];

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_en = 1'b0;

    // reference model state
    int          m_kind = 0;  // 0 idle, 1 erase, 2 program, 3 verify
    int          m_idx = 0;
    int          m_left = 0;
    bit          m_sec = 0, m_done = 0, m_err = 0, m_lk = 0;
    int          m_addr = 0;
    int          m_data = 0;
    int          m_rd = 0;
    int          exp_mem [NUM_WORDS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fusectl_top #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PROG_CYCLES (PROG_CYCLES)
    ) i_fusectl_top (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata), .cmd_lock (cmd_lock),
        .busy (busy), .done (done), .cmd_err (cmd_err), .rd_data (rd_data),
        .secured (secured), .fuse_we (fuse_we), .fuse_addr (fuse_addr),
        .fuse_wdata (fuse_wdata), .fuse_rdata (fuse_rdata)
    );

    // external fuse store
    initial begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            store[i]   = DATA_W'(8'hA5 ^ i);
            exp_mem[i] = 32'hA5 ^ i;
        end
    end
    always @(posedge clk) if (fuse_we) store[fuse_addr] <= fuse_wdata;
    assign fuse_rdata = store[fuse_addr];

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0; m_sec = 0; m_done = 0; m_err = 0; m_rd = 0; m_lk = 0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_kind == 1) begin
                exp_mem[m_idx] = 0;
                if (m_idx == NUM_WORDS - 1) begin m_kind = 0; m_done = 1; m_sec = 0; end
                else m_idx++;
            end else if (m_kind == 2) begin
                exp_mem[m_addr] = m_data;
                m_left--;
                if (m_left == 0) begin m_kind = 0; m_done = 1; if (m_lk) m_sec = 1; end
            end else if (m_kind == 3) begin
                m_rd = exp_mem[m_addr]; m_done = 1; m_kind = 0;
            end else if (cmd_valid) begin
                case (cmd_op)
                    2'b00: begin m_kind = 1; m_idx = 0; end
                    2'b01: if (m_sec) m_err = 1;
                           else begin m_kind = 2; m_left = PROG_CYCLES; m_addr = int'(cmd_addr);
                                      m_data = int'(cmd_wdata); m_lk = cmd_lock; end
                    2'b10: if (m_sec) begin m_err = 1; m_rd = 0; end
                           else begin m_kind = 3; m_addr = int'(cmd_addr); end
                    default: begin m_sec = 1; m_done = 1; end
                endcase
            end
        end
    end

    // compare every output against the model, away from the rising edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(cur_req, "busy", int'(busy), int'(m_kind != 0));
            check(cur_req, "done", int'(done), int'(m_done));
            check(cur_req, "cmd_err", int'(cmd_err), int'(m_err));
            check(cur_req, "secured", int'(secured), int'(m_sec));
            check(cur_req, "rd_data", int'(rd_data), m_rd);
            check(cur_req, "fuse_we", int'(fuse_we), int'(m_kind == 1 || m_kind == 2));
            if (m_kind == 1) begin
                check(cur_req, "fuse_addr", int'(fuse_addr), m_idx);
                check(cur_req, "fuse_wdata", int'(fuse_wdata), 0);
            end else if (m_kind == 2) begin
                check(cur_req, "fuse_addr", int'(fuse_addr), m_addr);
                check(cur_req, "fuse_wdata", int'(fuse_wdata), m_data);
            end
        end
    end

    task automatic issue(input logic [1:0] op, input int a, input int d, input logic lk, input string req);
        cur_req = req;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a);
        cmd_wdata = DATA_W'(d); cmd_lock = lk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_lock = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_kind != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int busy_len;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "secured", int'(secured), 0);
        check("R1", "fuse_we", int'(fuse_we), 0);
        check("R1", "rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // R5: verify a factory word
        issue(2'b10, 3, 0, 1'b0, "R5");
        wait_idle();
        check("R5", "verify word3", int'(rd_data), 32'hA5 ^ 3);

        // R4: program word 5, with a verify presented mid-write (R2)
        issue(2'b01, 5, 8'h3C, 1'b0, "R4");
        cur_req = "R2";
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 4'd9;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2", "err on busy cmd", int'(cmd_err), 0);
        wait_idle();
        check("R4", "store word5", int'(store[5]), 8'h3C);
        issue(2'b10, 5, 0, 1'b0, "R5");
        wait_idle();
        check("R5", "verify word5", int'(rd_data), 8'h3C);

        // R6: secure, no busy
        issue(2'b11, 0, 0, 1'b0, "R6");
        check("R6", "secured", int'(secured), 1);
        check("R6", "busy", int'(busy), 0);
        @(negedge clk);

        // R8: refused program
        issue(2'b01, 7, 8'hFF, 1'b0, "R8");
        check("R8", "cmd_err", int'(cmd_err), 1);
        check("R8", "fuse_we", int'(fuse_we), 0);
        @(negedge clk);
        check("R8", "cmd_err one cycle", int'(cmd_err), 0);
        check("R8", "store word7", int'(store[7]), 32'hA5 ^ 7);

        // R9: refused verify returns zeros
        issue(2'b10, 5, 0, 1'b0, "R9");
        check("R9", "rd_data", int'(rd_data), 0);
        check("R9", "done", int'(done), 0);
        check("R9", "cmd_err", int'(cmd_err), 1);
        @(negedge clk);

        // R6/R10: secure again while locked keeps the lock
        issue(2'b11, 0, 0, 1'b0, "R10");
        check("R10", "still secured", int'(secured), 1);
        @(negedge clk);

        // R3/R10: bulk erase clears store and lock
        issue(2'b00, 0, 0, 1'b0, "R3");
        busy_len = 1;
        while (busy) begin @(negedge clk); if (busy) busy_len++; end
        check("R3", "erase busy cycles", busy_len, NUM_WORDS);
        check("R3", "done after erase", int'(done), 1);
        check("R10", "secured after erase", int'(secured), 0);
        for (int i = 0; i < NUM_WORDS; i++) check("R10", "erased word", int'(store[i]), 0);

        // R7: program with lock-after flag
        issue(2'b01, 2, 8'h5A, 1'b1, "R7");
        check("R7", "secured during write", int'(secured), 0);
        wait_idle();
        check("R7", "secured after write", int'(secured), 1);
        check("R7", "store word2", int'(store[2]), 8'h5A);
        issue(2'b10, 2, 0, 1'b0, "R9");
        check("R9", "rd_data locked", int'(rd_data), 0);
        @(negedge clk);

        // R10: erase again, then verify reads zero
        issue(2'b00, 0, 0, 1'b0, "R10");
        wait_idle();
        issue(2'b10, 2, 0, 1'b0, "R10");
        wait_idle();
        check("R10", "verify after erase", int'(rd_data), 0);
        check("R10", "unlocked", int'(secured), 0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule